// File: doc/BRIEF.md
# Byte FIFO with Watermark Data Request and Polled Status Words

This block is the byte queue that sits between a 32-bit host register port and a serial-bus command sequencer. It also produces the status and extended-status words that software polls. A direction input picks the roles of the two sides. In a write transfer, the host fills the queue with 1, 2 or 4 bytes per access and the sequencer drains it one byte at a time. In a read transfer, the sequencer fills the queue one byte at a time and the host drains it with 1, 2 or 4 byte pops.

The block compares the fill level against a programmable high mark and low mark. It raises a data-request flag when the host should move more bytes in the direction of the active transfer. Error events from the sequencer are held in sticky flags until the host clears them with an error-reset strobe. Misuse of the queue is caught here and reported through those same sticky flags. Misuse means an illegal access size, pushing into a full queue, or popping more bytes than the queue holds.

Top module: `wmark_fifo_stat`

## Requirements
- R1: After reset the queue is empty, `stat_word` reads 0, and `wm_word` reads 32'h0000C040 (high mark 12 in bits 15:12, low mark 4 in bits 7:4).
- R2: A host access of N bytes (N = 1, 2 or 4) moves the bytes of `reg_wdata`/`reg_rdata` in lane order, lane 0 (bits 7:0) first. `reg_rdata` shows the N oldest bytes in lanes 0..N-1, and the lanes at N and above read zero.
- R3: A host access with `reg_nbytes` other than 1, 2 or 4 sets the access-error flag (status bit 28) and leaves the queue unchanged.
- R4: With `dir_rd`=0, only host pushes and sequencer pops act on the queue. With `dir_rd`=1, only sequencer pushes and host pops act. Operations from the other side have no effect. `seq_rbyte` always shows the oldest byte.
- R5: A push larger than the free space, or a pop larger than the fill, sets the overrun flag (status bit 29) and moves no bytes. The fill never exceeds DEPTH.
- R6: Status bits 7:0 give the current fill in bytes, updated the cycle after each accepted operation.
- R7: A write to `wm_wr` takes the high mark from `wm_wdata[15:12]` and the low mark from `wm_wdata[7:4]`, and ignores every other bit. `wm_word` reads back only those two fields.
- R8: Extended status bits 31:24 hold DEPTH. Bit 9 is set when fill >= high mark, bit 8 when fill <= low mark, bit 7 mirrors `port_busy` and bit 6 mirrors `eng_busy`. All other bits are zero.
- R9: With `dir_rd`=0, data request (status bit 25) is set when fill <= low mark and `xfer_remain` is nonzero.
- R10: With `dir_rd`=1, data request is set when fill is nonzero and either fill >= high mark or fill >= `xfer_remain`.
- R11: The flags for invalid command (bit 31), parity (30), overrun (29), access (28), lost arbitration (27), NACK (26), command complete (24) and stop error (23) are sticky. `err_clr` clears them, except that an event arriving in the same cycle as `err_clr` stays set.
- R12: Status bit 15 is the OR of every flag in R11 and data request. Bit 9 mirrors `port_busy`, bit 8 mirrors `eng_busy`, and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Host queue access strobe |
| reg_we | input | 1 | 1 = host push, 0 = host pop |
| reg_nbytes | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| reg_wdata | input | 32 | Host push data, lane 0 first |
| reg_rdata | output | 32 | Oldest bytes for a host pop, unused lanes zero |
| seq_push | input | 1 | Sequencer pushes one byte |
| seq_wbyte | input | 8 | Byte pushed by the sequencer |
| seq_pop | input | 1 | Sequencer pops one byte |
| seq_rbyte | output | 8 | Oldest byte in the queue |
| dir_rd | input | 1 | Active transfer direction, 1 = read |
| xfer_remain | input | 16 | Bytes the host still has to move for this transfer |
| wm_wr | input | 1 | Watermark register write strobe |
| wm_wdata | input | 32 | Watermark write data |
| wm_word | output | 32 | Watermark register readback |
| evt_invcmd | input | 1 | Invalid command event |
| evt_parity | input | 1 | Parity error event |
| evt_access | input | 1 | Access error event |
| evt_arblost | input | 1 | Lost arbitration event |
| evt_nack | input | 1 | NACK event |
| evt_stoperr | input | 1 | Stop error event |
| evt_done | input | 1 | Command complete event |
| err_clr | input | 1 | Error-reset strobe |
| port_busy | input | 1 | Bus port busy indication |
| eng_busy | input | 1 | Engine busy indication |
| stat_word | output | 32 | Status word |
| estat_word | output | 32 | Extended status word |

## Verification
On every cycle, the assertions check the invariants that link the outputs: the fill bound, the hold of a rejected operation, the stickiness of the flags, the agreement of the high-mark flag with the fill and the mark, and the two cases where data request must stay low. The byte order through the lanes, the ignoring of off-direction operations, the rule that an event wins over a clear in the same cycle, and the watermark field masking only show up in the bench's scenarios. There, a behavioural queue model is compared with the outputs every cycle.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

  typedef struct packed {
    logic inv;
    logic par;
    logic ovr;
    logic acc;
    logic arb;
    logic nack;
    logic done;
    logic stop;
  } flag_t;

  function automatic logic size_ok(input logic [2:0] n);
    return (n == 3'd1) || (n == 3'd2) || (n == 3'd4);
  endfunction

  // fill is zero-extended to 9 bits by the caller
  function automatic logic dreq_calc(input logic rd, input logic [8:0] fill,
                                     input logic [3:0] hi, input logic [3:0] lo,
                                     input logic [15:0] remain);
    logic [15:0] f16;
    f16 = {7'd0, fill};
    if (rd)
      return (fill != 9'd0) && ((fill >= {5'd0, hi}) || (f16 >= remain));
    return (fill <= {5'd0, lo}) && (remain != 16'd0);
  endfunction

  function automatic logic [31:0] pack_status(input flag_t f, input logic dreq,
                                              input logic pbusy, input logic ebusy,
                                              input logic [7:0] cnt);
    logic any;
    any = f.inv | f.par | f.ovr | f.acc | f.arb | f.nack | f.stop | f.done | dreq;
    return {f.inv, f.par, f.ovr, f.acc, f.arb, f.nack, dreq, f.done, f.stop,
            7'd0, any, 5'd0, pbusy, ebusy, cnt};
  endfunction

endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_n,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  input  logic [2:0]    rd_n,
  output logic [31:0]   head_word,
  output logic [CW-1:0] count
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [2:0]    wr_step, rd_step;

  assign wr_step = wr_en ? wr_n : 3'd0;
  assign rd_step = rd_en ? rd_n : 3'd0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (wr_en && (i < int'(wr_n)))
        mem[wp + AW'(i)] <= wr_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(wr_step);
      rp    <= rp + AW'(rd_step);
      count <= count + CW'(wr_step) - CW'(rd_step);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign head_word[8*g +: 8] = mem[rp + AW'(g)];
  end

endmodule

// File: rtl/wmf_level.sv
module wmf_level #(
  parameter int CW = 5,
  parameter logic [3:0] HI_RST = 4'd12,
  parameter logic [3:0] LO_RST = 4'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wm_wr,
  input  logic [3:0]    hi_in,
  input  logic [3:0]    lo_in,
  input  logic [CW-1:0] fill,
  input  logic          dir_rd,
  input  logic [15:0]   remain,
  output logic [3:0]    hi_q,
  output logic [3:0]    lo_q,
  output logic          at_hi,
  output logic          at_lo,
  output logic          dreq
);
  import wmf_pkg::*;

  logic [8:0] fill9;
  assign fill9 = 9'(fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RST;
      lo_q <= LO_RST;
    end else if (wm_wr) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  assign at_hi = fill9 >= {5'd0, hi_q};
  assign at_lo = fill9 <= {5'd0, lo_q};
  assign dreq  = dreq_calc(dir_rd, fill9, hi_q, lo_q, remain);

endmodule

// File: rtl/wmf_flags.sv
module wmf_flags (
  input  logic           clk,
  input  logic           rst_n,
  input  wmf_pkg::flag_t set,
  input  logic           clr,
  output wmf_pkg::flag_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set;
  end

endmodule

// File: rtl/wmark_fifo_stat.sv
module wmark_fifo_stat #(
  parameter int DEPTH = 16,
  parameter logic [3:0] HI_RST = 4'd12,
  parameter logic [3:0] LO_RST = 4'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_we,
  input  logic [2:0]  reg_nbytes,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        seq_push,
  input  logic [7:0]  seq_wbyte,
  input  logic        seq_pop,
  output logic [7:0]  seq_rbyte,
  input  logic        dir_rd,
  input  logic [15:0] xfer_remain,
  input  logic        wm_wr,
  input  logic [31:0] wm_wdata,
  output logic [31:0] wm_word,
  input  logic        evt_invcmd,
  input  logic        evt_parity,
  input  logic        evt_access,
  input  logic        evt_arblost,
  input  logic        evt_nack,
  input  logic        evt_stoperr,
  input  logic        evt_done,
  input  logic        err_clr,
  input  logic        port_busy,
  input  logic        eng_busy,
  output logic [31:0] stat_word,
  output logic [31:0] estat_word
);
  import wmf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // named internal events, also watched by the checker
  logic          size_good, size_bad;
  logic          wr_req, rd_req, wr_ok, rd_ok, ovr_evt;
  logic [2:0]    wr_n, rd_n;
  logic [31:0]   wr_data, head_word;
  logic [CW-1:0] count, room;
  logic [3:0]    hi_q, lo_q;
  logic          at_hi, at_lo, dreq;
  flag_t         flag_set, flag_q;
  logic          wm_unused_bits;

  assign size_good = size_ok(reg_nbytes);
  assign size_bad  = reg_req && !size_good;

  assign wr_req  = dir_rd ? seq_push : (reg_req && reg_we && size_good);
  assign wr_n    = dir_rd ? 3'd1 : reg_nbytes;
  assign wr_data = dir_rd ? {24'd0, seq_wbyte} : reg_wdata;
  assign rd_req  = dir_rd ? (reg_req && !reg_we && size_good) : seq_pop;
  assign rd_n    = dir_rd ? reg_nbytes : 3'd1;

  assign room    = CW'(DEPTH) - count;
  assign wr_ok   = wr_req && (CW'(wr_n) <= room);
  assign rd_ok   = rd_req && (CW'(rd_n) <= count);
  assign ovr_evt = (wr_req && !wr_ok) || (rd_req && !rd_ok);

  wmf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_n(wr_n), .wr_data(wr_data),
    .rd_en(rd_ok), .rd_n(rd_n),
    .head_word(head_word), .count(count)
  );

  wmf_level #(.CW(CW), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_level (
    .clk(clk), .rst_n(rst_n),
    .wm_wr(wm_wr), .hi_in(wm_wdata[15:12]), .lo_in(wm_wdata[7:4]),
    .fill(count), .dir_rd(dir_rd), .remain(xfer_remain),
    .hi_q(hi_q), .lo_q(lo_q), .at_hi(at_hi), .at_lo(at_lo), .dreq(dreq)
  );

  assign flag_set = '{inv:  evt_invcmd,
                      par:  evt_parity,
                      ovr:  ovr_evt,
                      acc:  evt_access | size_bad,
                      arb:  evt_arblost,
                      nack: evt_nack,
                      done: evt_done,
                      stop: evt_stoperr};

  wmf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(err_clr), .q(flag_q)
  );

  for (genvar g = 0; g < 4; g++) begin : g_rlane
    assign reg_rdata[8*g +: 8] = (size_good && (g < int'(reg_nbytes))) ?
                                 head_word[8*g +: 8] : 8'd0;
  end

  assign seq_rbyte      = head_word[7:0];
  assign wm_word        = {16'd0, hi_q, 4'd0, lo_q, 4'd0};
  assign wm_unused_bits = ^{wm_wdata[31:16], wm_wdata[11:8], wm_wdata[3:0]};
  assign stat_word      = pack_status(flag_q, dreq, port_busy, eng_busy, 8'(count));
  assign estat_word     = {8'(DEPTH), 14'd0, at_hi, at_lo, port_busy, eng_busy, 6'd0};

endmodule

// File: rtl/wmark_fifo_stat_chk.sv
module wmark_fifo_stat_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dir_rd,
  input logic [15:0] xfer_remain,
  input logic        err_clr,
  input logic [31:0] stat_word,
  input logic [31:0] estat_word,
  input logic [31:0] wm_word,
  input logic        wr_ok,
  input logic        rd_ok,
  input logic        ovr_evt
);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[7:0] <= 8'(DEPTH));

  // R5
  ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_word[29]);

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !wr_ok && !rd_ok) |=> $stable(stat_word[7:0]));

  // R11
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[26] && !err_clr) |=> stat_word[26]);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[24] && !err_clr) |=> stat_word[24]);

  // R8
  hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    estat_word[9] == (stat_word[7:0] >= {4'd0, wm_word[15:12]}));

  // R10
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && stat_word[7:0] == 8'd0) |-> !stat_word[25]);

  // R9
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && xfer_remain == 16'd0) |-> !stat_word[25]);

endmodule

bind wmark_fifo_stat wmark_fifo_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .xfer_remain(xfer_remain),
  .err_clr(err_clr), .stat_word(stat_word), .estat_word(estat_word),
  .wm_word(wm_word), .wr_ok(wr_ok), .rd_ok(rd_ok), .ovr_evt(ovr_evt)
);

// File: tb/wmark_fifo_stat_tb.sv
module wmark_fifo_stat_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 0, reg_we = 0;
  logic [2:0]  reg_nbytes = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        seq_push = 0, seq_pop = 0;
  logic [7:0]  seq_wbyte = 0;
  logic [7:0]  seq_rbyte;
  logic        dir_rd = 0;
  logic [15:0] xfer_remain = 0;
  logic        wm_wr = 0;
  logic [31:0] wm_wdata = 0;
  logic [31:0] wm_word;
  logic        evt_invcmd = 0, evt_parity = 0, evt_access = 0, evt_arblost = 0;
  logic        evt_nack = 0, evt_stoperr = 0, evt_done = 0, err_clr = 0;
  logic        port_busy = 0, eng_busy = 0;
  logic [31:0] stat_word, estat_word;

  always #5 clk = ~clk;

  wmark_fifo_stat dut_i (.*);

  // behavioural model state
  byte unsigned q[$];
  int  m_hi = 12, m_lo = 4;
  bit  f_inv, f_par, f_ovr, f_acc, f_arb, f_nack, f_done, f_stop;
  int  nvec = 0, nbad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input int n);
    return n == 1 || n == 2 || n == 4;
  endfunction

  function automatic bit model_dreq();
    int f = q.size();
    if (dir_rd) return f > 0 && (f >= m_hi || f >= int'(xfer_remain));
    return f <= m_lo && xfer_remain != 0;
  endfunction

  task automatic compare();
    logic [31:0] es, ex;
    bit any;
    int n;
    any = f_inv | f_par | f_ovr | f_acc | f_arb | f_nack | f_done | f_stop | model_dreq();
    chk("R6 fill count", {24'd0, stat_word[7:0]}, q.size());
    chk("R3 access flag", stat_word[28], f_acc);
    chk("R5 overrun flag", stat_word[29], f_ovr);
    chk("R11 sticky flags", {stat_word[31:30], stat_word[27:26], stat_word[24:23]},
        {f_inv, f_par, f_arb, f_nack, f_done, f_stop});
    if (dir_rd) chk("R10 read data request", stat_word[25], model_dreq());
    else        chk("R9 write data request", stat_word[25], model_dreq());
    chk("R12 summary and busy", {stat_word[22:8]},
        {7'd0, any, 5'd0, port_busy, eng_busy});
    es = '0;
    es[31:24] = DEPTH;
    es[9] = q.size() >= m_hi;
    es[8] = q.size() <= m_lo;
    es[7] = port_busy;
    es[6] = eng_busy;
    chk("R8 extended status", estat_word, es);
    chk("R7 watermark readback", wm_word, (m_hi << 12) | (m_lo << 4));
    n = reg_nbytes;
    if (legal(n) && q.size() >= n) begin
      ex = '0;
      for (int i = 0; i < n; i++) ex[8*i +: 8] = q[i];
      chk("R2 host read lanes", reg_rdata, ex);
    end
    if (q.size() > 0) chk("R4 oldest byte", {24'd0, seq_rbyte}, q[0]);
  endtask

  task automatic model_step();
    int pre = q.size();
    bit szok = legal(reg_nbytes);
    bit wreq, rreq, wok, rok;
    int wn, rn;
    wreq = dir_rd ? seq_push : (reg_req && reg_we && szok);
    rreq = dir_rd ? (reg_req && !reg_we && szok) : seq_pop;
    wn = dir_rd ? 1 : reg_nbytes;
    rn = dir_rd ? reg_nbytes : 1;
    wok = wreq && wn <= DEPTH - pre;
    rok = rreq && rn <= pre;
    if (err_clr) {f_inv, f_par, f_ovr, f_acc, f_arb, f_nack, f_done, f_stop} = '0;
    if (reg_req && !szok) f_acc = 1;
    if ((wreq && !wok) || (rreq && !rok)) f_ovr = 1;
    f_inv |= evt_invcmd; f_par |= evt_parity; f_acc |= evt_access;
    f_arb |= evt_arblost; f_nack |= evt_nack; f_done |= evt_done; f_stop |= evt_stoperr;
    if (rok) for (int i = 0; i < rn; i++) void'(q.pop_front());
    if (wok) for (int i = 0; i < wn; i++)
      q.push_back(dir_rd ? seq_wbyte : reg_wdata[8*i +: 8]);
    if (wm_wr) begin
      m_hi = int'(wm_wdata[15:12]);
      m_lo = int'(wm_wdata[7:4]);
    end
  endtask

  task automatic idle();
    reg_req = 0; reg_we = 0; reg_nbytes = 0; reg_wdata = 0;
    seq_push = 0; seq_pop = 0; seq_wbyte = 0; wm_wr = 0; wm_wdata = 0;
    {evt_invcmd, evt_parity, evt_access, evt_arblost, evt_nack, evt_stoperr, evt_done} = '0;
    err_clr = 0;
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle();
  endtask

  task automatic host(input bit we, input int n, input logic [31:0] d);
    reg_req = 1; reg_we = we; reg_nbytes = 3'(n); reg_wdata = d;
    tick();
  endtask

  task automatic sq(input bit push, input bit pop, input logic [7:0] b);
    seq_push = push; seq_pop = pop; seq_wbyte = b;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk("R1 reset status", stat_word, 32'h0);
    chk("R1 reset watermark", wm_word, 32'h0000C040);
    tick();

    // write direction: host fills, sequencer drains
    dir_rd = 0; xfer_remain = 20;
    host(1, 4, 32'h44332211);
    host(1, 2, 32'hDEAD6655);
    host(1, 1, 32'hFFFFFF77);
    host(1, 4, 32'hBBAA9988);
    host(1, 4, 32'hFFEEDDCC);
    host(1, 2, 32'h00001234);   // R5 only one slot free
    host(1, 1, 32'h000000A5);   // fills to 16
    host(1, 1, 32'h0000005A);   // R5 push into full
    err_clr = 1; tick();
    host(1, 3, 32'h01020304);   // R3 size 3
    host(0, 0, 32'h0);          // R3 size 0
    host(1, 5, 32'h0);          // R3 size 5
    err_clr = 1; evt_nack = 1; tick(); // R11 event wins over clear
    sq(1, 0, 8'h99);            // R4 off-direction push ignored
    host(0, 2, 32'h0);          // R4 off-direction host pop ignored
    for (int i = 0; i < 16; i++) begin
      xfer_remain = 16'(i % 3);
      sq(0, 1, 8'h00);
    end
    sq(0, 1, 8'h00);            // R5 pop from empty
    xfer_remain = 0; tick();    // R9 nothing left
    xfer_remain = 5; tick();

    // events and busy mirrors
    evt_invcmd = 1; tick();
    evt_parity = 1; port_busy = 1; tick();
    evt_arblost = 1; eng_busy = 1; tick();
    evt_stoperr = 1; evt_done = 1; evt_access = 1; tick();
    port_busy = 0; tick();
    err_clr = 1; tick();
    eng_busy = 0; tick();

    // R7 watermark write with junk in other bits: hi 6, lo 2
    wm_wr = 1; wm_wdata = 32'hABCD6F2E; tick();
    tick();

    // read direction: sequencer fills, host drains
    dir_rd = 1; xfer_remain = 10;
    for (int i = 0; i < 8; i++) sq(1, 0, 8'(8'h80 + i));
    host(1, 4, 32'h11111111);   // R4 off-direction host push ignored
    sq(0, 1, 8'h00);            // R4 off-direction sequencer pop ignored
    host(0, 4, 32'h0);
    xfer_remain = 6;
    host(0, 2, 32'h0);
    xfer_remain = 4;
    seq_push = 1; seq_wbyte = 8'hC1; reg_req = 1; reg_we = 0; reg_nbytes = 1; tick();
    xfer_remain = 3; tick();
    host(0, 4, 32'h0);          // R5 pop more than fill
    xfer_remain = 1; tick();
    host(0, 2, 32'h0);
    host(0, 1, 32'h0);
    xfer_remain = 0; tick();    // R10 empty, no request
    for (int i = 0; i < 18; i++) sq(1, 0, 8'(8'h40 + i)); // R5 push past full
    host(0, 4, 32'h0);
    host(0, 4, 32'h0);
    err_clr = 1; tick();
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule